// File: doc/BRIEF.md
# UART Receive Buffer with Trigger Level and Character-Time Timeout

This block sits between the serial deserialiser of a PC-style UART and the CPU register interface. Every character the deserialiser completes arrives with a one-cycle strobe together with three error flags (parity, framing, break). The block stores the character and its flags, reports line status for the character at the head, and signals when the CPU should read. In FIFO mode it holds up to sixteen characters. In holding mode it holds one character.

Two conditions tell the interrupt logic that the CPU should read. The data-available condition rises once the stored count reaches a programmable trigger threshold. The timeout condition rises when characters have been waiting, with neither a CPU read nor a new arrival, for four character times. A character time is measured in baud ticks. It is derived from the programmed word length, parity enable and stop-bit count, so the idle window tracks the line format. Interrupt prioritisation and the serial shifter are outside the block.

The timeout timer is a three-state machine:
- TMO_IDLE: the buffer is empty.
- TMO_COUNT: baud ticks are being counted.
- TMO_FIRED: the window has elapsed.

Its transitions are:
- IDLE to COUNT when the buffer is non-empty.
- COUNT to COUNT with the counter cleared on service, meaning a receive strobe or a data-register read.
- COUNT to FIRED when the tick counter reaches the last tick of the window.
- FIRED to COUNT on service.
- Any state to IDLE whenever the buffer is empty.

Top module: `uart_rx_buffer`

## Requirements
- R1: After reset:
  - FIFO mode is off and the trigger code is 00.
  - The buffer is empty and `rd_data` is 0.
  - `lsr` bits 0..4 and 7 are 0.
  - `rx_data_avail`, `rx_timeout` and `tx_fifo_clr` are 0.
- R2: A control write (`fcr_wr`) takes `fcr_data` bit 0 as the new mode (1 = FIFO mode, 0 = holding mode). A write that changes the mode also empties the receive buffer.
- R3: A control write with `fcr_data` bit 1 = 1 empties the receive buffer, and a byte arriving in the same cycle is dropped. A control write with bit 2 = 1 makes `tx_fifo_clr` high for exactly the one cycle after the write. A 0 in either bit leaves the buffer and `tx_fifo_clr` untouched.
- R4: `fcr_data` bits 7:6 set the trigger level: 00 = 1, 01 = 4, 10 = 8, 11 = 14 characters. In FIFO mode `rx_data_avail` is 1 exactly when the stored count is at least the trigger level.
- R5: Characters leave in arrival order. Up to 16 are stored in FIFO mode. `rd_data` shows the head byte while the buffer is non-empty, and 0 otherwise. A `rbr_rd` pulse removes the head.
- R6: A byte that arrives when the buffer is full is discarded, and `lsr` bit 1 (overrun) sets. The buffer is full at 16 characters in FIFO mode and at 1 in holding mode. A byte that arrives in the same cycle as a read of a full buffer is accepted. An `lsr_rd` pulse clears the overrun bit unless another overrun occurs in the same cycle.
- R7: In holding mode `rx_data_avail` equals `lsr` bit 0, and `rx_timeout` stays 0.
- R8: The `lsr` bits report as follows:
  - Bit 0 is 1 when the buffer is non-empty.
  - Bits 2, 3 and 4 are the parity, framing and break flags of the head character, and are 0 when the buffer is empty.
  - Bit 5 copies `tx_hold_empty`, and bit 6 copies `tx_idle`.
- R9: In FIFO mode `lsr` bit 7 is 1 while any stored character carries at least one error flag. In holding mode bit 7 is 0.
- R10: One character time is B = 7 + L + P + S baud ticks. Here L = `lcr_fmt[1:0]` (word length 5 + L bits), P = `lcr_fmt[3]` (parity enabled) and S = `lcr_fmt[2]` (two stop bits). The window is 4·B ticks.
  - With `baud_tick` high on every cycle, a byte stored into an empty buffer raises `rx_timeout` 4·B+1 clock edges after the edge that stored it.
  - After service on a non-empty buffer, `rx_timeout` rises 4·B edges after the service edge.
- R11: The cycle after any `rx_valid` or `rbr_rd`, `rx_timeout` is 0. `rx_timeout` is 1 only in FIFO mode with a non-empty buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_valid | input | 1 | Received character strobe from the deserialiser |
| rx_byte | input | 8 | Received character |
| rx_par_err | input | 1 | Parity error flag of the received character |
| rx_frm_err | input | 1 | Framing error flag of the received character |
| rx_brk | input | 1 | Break flag of the received character |
| baud_tick | input | 1 | One pulse per serial bit time |
| lcr_fmt | input | 4 | Word format: [1:0] length code, [2] two stop bits, [3] parity enabled |
| fcr_wr | input | 1 | FIFO-control register write strobe |
| fcr_data | input | 8 | FIFO-control write data |
| rbr_rd | input | 1 | CPU read of the receive data register |
| lsr_rd | input | 1 | CPU read of the line-status register |
| tx_hold_empty | input | 1 | Transmit holding-empty status, reported in lsr bit 5 |
| tx_idle | input | 1 | Transmitter idle status, reported in lsr bit 6 |
| rd_data | output | 8 | Head character |
| lsr | output | 8 | Line-status bits |
| rx_data_avail | output | 1 | Data-available interrupt condition |
| rx_timeout | output | 1 | Character-timeout interrupt condition |
| tx_fifo_clr | output | 1 | One-cycle request to empty the transmit FIFO |

## Verification
The hardest state to reach from the ports is the exact edge on which the timeout fires for each of the sixteen line formats. It must also be shown that the window starts one edge later for a byte stored into an empty buffer than for service on a non-empty one. The bench holds `baud_tick` high and flushes before each format. It counts edges from the storing edge to the rise of `rx_timeout`, then stores a second byte while the timer is in TMO_FIRED and counts again. The overrun case of a full FIFO is reached by filling all sixteen entries under every trigger code and offering a seventeenth byte.

// File: rtl/uart_rxb_pkg.sv
package uart_rxb_pkg;

    localparam int TMO_CNT_W = 6;

    typedef struct packed {
        logic       brk;
        logic       frm;
        logic       par;
        logic [7:0] data;
    } rx_entry_t;

    typedef enum logic [1:0] {
        TMO_IDLE,
        TMO_COUNT,
        TMO_FIRED
    } tmo_state_t;

    // bits per character: start + data(5+len) + parity + stop(1+two)
    function automatic logic [3:0] char_bits(input logic [3:0] fmt);
        return 4'd7 + {2'b00, fmt[1:0]} + {3'b000, fmt[3]} + {3'b000, fmt[2]};
    endfunction

endpackage

// File: rtl/uart_rxb_store.sv
module uart_rxb_store
    import uart_rxb_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CW = $clog2(DEPTH + 1),
    localparam int AW = $clog2(DEPTH)
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      clear,
    input  logic      push,
    input  rx_entry_t push_entry,
    input  logic      pop,
    input  logic      single,
    output rx_entry_t head,
    output logic [CW-1:0] count,
    output logic [CW-1:0] err_cnt,
    output logic      drop_evt
);

    rx_entry_t mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic full, do_pop, do_push;
    logic push_err, pop_err;

    assign full     = single ? (count != '0) : (count == CW'(DEPTH));
    assign do_pop   = !clear && pop && (count != '0);
    assign do_push  = !clear && push && (!full || do_pop);
    assign drop_evt = !clear && push && full && !do_pop;
    assign head     = mem[rd_ptr];
    assign push_err = push_entry.par | push_entry.frm | push_entry.brk;
    assign pop_err  = head.par | head.frm | head.brk;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            count   <= '0;
            err_cnt <= '0;
        end else if (clear) begin
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            count   <= '0;
            err_cnt <= '0;
        end else begin
            if (do_push) begin
                mem[wr_ptr] <= push_entry;
                wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            end
            if (do_pop) begin
                rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            end
            count   <= count + CW'(do_push) - CW'(do_pop);
            err_cnt <= err_cnt + CW'(do_push && push_err) - CW'(do_pop && pop_err);
        end
    end

endmodule

// File: rtl/uart_rxb_timeout.sv
module uart_rxb_timeout
    import uart_rxb_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       empty,
    input  logic       service,
    input  logic       baud_tick,
    input  logic [3:0] bits,
    output logic       fired
);

    tmo_state_t st, st_n;
    logic [TMO_CNT_W-1:0] cnt, cnt_n, limit;

    assign limit = {bits, 2'b00};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st  <= TMO_IDLE;
            cnt <= '0;
        end else begin
            st  <= st_n;
            cnt <= cnt_n;
        end
    end

    always_comb begin
        st_n  = st;
        cnt_n = cnt;
        unique case (st)
            TMO_IDLE: begin
                if (!empty) begin
                    st_n  = TMO_COUNT;
                    cnt_n = '0;
                end
            end
            TMO_COUNT: begin
                if (service) begin
                    cnt_n = '0;
                end else if (baud_tick) begin
                    if (cnt == limit - 1'b1) st_n = TMO_FIRED;
                    else                     cnt_n = cnt + 1'b1;
                end
            end
            TMO_FIRED: begin
                if (service) begin
                    st_n  = TMO_COUNT;
                    cnt_n = '0;
                end
            end
            default: st_n = TMO_IDLE;
        endcase
        if (empty) begin
            st_n  = TMO_IDLE;
            cnt_n = '0;
        end
    end

    assign fired = (st == TMO_FIRED) && !empty;

endmodule

// File: rtl/uart_rx_buffer.sv
module uart_rx_buffer
    import uart_rxb_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_valid,
    input  logic [7:0] rx_byte,
    input  logic       rx_par_err,
    input  logic       rx_frm_err,
    input  logic       rx_brk,
    input  logic       baud_tick,
    input  logic [3:0] lcr_fmt,
    input  logic       fcr_wr,
    input  logic [7:0] fcr_data,
    input  logic       rbr_rd,
    input  logic       lsr_rd,
    input  logic       tx_hold_empty,
    input  logic       tx_idle,
    output logic [7:0] rd_data,
    output logic [7:0] lsr,
    output logic       rx_data_avail,
    output logic       rx_timeout,
    output logic       tx_fifo_clr
);

    localparam int CW = $clog2(DEPTH + 1);

    logic          fifo_en;
    logic [1:0]    trig_code;
    logic          overrun;
    logic          clear;
    logic          drop_evt;
    logic          nonempty;
    logic          tmo_fired;
    logic [CW-1:0] rx_count, err_cnt, trig_lvl;
    rx_entry_t     in_entry, head;
    logic          unused_fcr_bits;

    assign unused_fcr_bits = ^fcr_data[5:3];
    assign clear    = fcr_wr && (fcr_data[1] || (fcr_data[0] != fifo_en));
    assign in_entry = '{brk: rx_brk, frm: rx_frm_err, par: rx_par_err, data: rx_byte};
    assign nonempty = (rx_count != '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fifo_en     <= 1'b0;
            trig_code   <= 2'b00;
            overrun     <= 1'b0;
            tx_fifo_clr <= 1'b0;
        end else begin
            tx_fifo_clr <= fcr_wr && fcr_data[2];
            if (fcr_wr) begin
                fifo_en   <= fcr_data[0];
                trig_code <= fcr_data[7:6];
            end
            if (drop_evt)    overrun <= 1'b1;
            else if (lsr_rd) overrun <= 1'b0;
        end
    end

    always_comb begin
        unique case (trig_code)
            2'b00: trig_lvl = CW'(1);
            2'b01: trig_lvl = CW'(4);
            2'b10: trig_lvl = CW'(8);
            default: trig_lvl = CW'(14);
        endcase
    end

    uart_rxb_store #(.DEPTH(DEPTH)) i_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (clear),
        .push       (rx_valid),
        .push_entry (in_entry),
        .pop        (rbr_rd),
        .single     (!fifo_en),
        .head       (head),
        .count      (rx_count),
        .err_cnt    (err_cnt),
        .drop_evt   (drop_evt)
    );

    uart_rxb_timeout i_tmo (
        .clk       (clk),
        .rst_n     (rst_n),
        .empty     (!nonempty),
        .service   (rx_valid || rbr_rd),
        .baud_tick (baud_tick),
        .bits      (char_bits(lcr_fmt)),
        .fired     (tmo_fired)
    );

    assign rd_data       = nonempty ? head.data : 8'h00;
    assign rx_data_avail = fifo_en ? (rx_count >= trig_lvl) : nonempty;
    assign rx_timeout    = fifo_en && tmo_fired;
    assign lsr = {fifo_en && (err_cnt != '0), tx_idle, tx_hold_empty,
                  nonempty && head.brk, nonempty && head.frm,
                  nonempty && head.par, overrun, nonempty};

endmodule

// File: rtl/uart_rx_buffer_chk.sv
module uart_rx_buffer_chk #(
    parameter int DEPTH = 16,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rx_valid,
    input logic          rbr_rd,
    input logic          lsr_rd,
    input logic          fcr_wr,
    input logic [7:0]    fcr_data,
    input logic [7:0]    lsr,
    input logic          rx_data_avail,
    input logic          rx_timeout,
    input logic          fifo_en,
    input logic [CW-1:0] rx_count
);

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        rx_count <= CW'(DEPTH)); // R5

    AST_OVERRUN_SET: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid && !rbr_rd && !fcr_wr && fifo_en && rx_count == CW'(DEPTH) |=> lsr[1]); // R6

    AST_OVERRUN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        lsr_rd && !rx_valid |=> !lsr[1]); // R6

    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        fcr_wr && fcr_data[1] |=> !lsr[0]); // R3

    AST_HOLD_MODE_AVAIL: assert property (@(posedge clk) disable iff (!rst_n)
        !fifo_en |-> (rx_data_avail == lsr[0]) && !rx_timeout); // R7

    AST_TIMEOUT_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        rx_timeout |-> lsr[0] && fifo_en); // R11

    AST_SERVICE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid || rbr_rd |=> !rx_timeout); // R11

endmodule

bind uart_rx_buffer uart_rx_buffer_chk #(.DEPTH(DEPTH)) i_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .rx_valid      (rx_valid),
    .rbr_rd        (rbr_rd),
    .lsr_rd        (lsr_rd),
    .fcr_wr        (fcr_wr),
    .fcr_data      (fcr_data),
    .lsr           (lsr),
    .rx_data_avail (rx_data_avail),
    .rx_timeout    (rx_timeout),
    .fifo_en       (fifo_en),
    .rx_count      (rx_count)
);

// File: tb/test_uart_rx_buffer.sv
module test_uart_rx_buffer;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_byte = 8'h00;
    logic       rx_par_err = 1'b0, rx_frm_err = 1'b0, rx_brk = 1'b0;
    logic       baud_tick = 1'b0;
    logic [3:0] lcr_fmt = 4'h3;
    logic       fcr_wr = 1'b0;
    logic [7:0] fcr_data = 8'h00;
    logic       rbr_rd = 1'b0, lsr_rd = 1'b0;
    logic       tx_hold_empty = 1'b1, tx_idle = 1'b0;
    logic [7:0] rd_data, lsr;
    logic       rx_data_avail, rx_timeout, tx_fifo_clr;

    int checks = 0;
    int errors = 0;

    always #5ns clk = ~clk;

    uart_rx_buffer i_uart_rx_buffer (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .rx_par_err(rx_par_err), .rx_frm_err(rx_frm_err), .rx_brk(rx_brk),
        .baud_tick(baud_tick), .lcr_fmt(lcr_fmt), .fcr_wr(fcr_wr),
        .fcr_data(fcr_data), .rbr_rd(rbr_rd), .lsr_rd(lsr_rd),
        .tx_hold_empty(tx_hold_empty), .tx_idle(tx_idle), .rd_data(rd_data),
        .lsr(lsr), .rx_data_avail(rx_data_avail), .rx_timeout(rx_timeout),
        .tx_fifo_clr(tx_fifo_clr)
    );

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic push(input logic [7:0] b, input logic [2:0] fl);
        rx_valid = 1'b1; rx_byte = b;
        {rx_brk, rx_frm_err, rx_par_err} = fl;
        @(negedge clk);
        rx_valid = 1'b0; {rx_brk, rx_frm_err, rx_par_err} = 3'b000;
    endtask

    task automatic rd();
        rbr_rd = 1'b1; @(negedge clk); rbr_rd = 1'b0;
    endtask

    task automatic wr_fcr(input logic [7:0] v);
        fcr_wr = 1'b1; fcr_data = v; @(negedge clk); fcr_wr = 1'b0;
    endtask

    task automatic rd_lsr();
        lsr_rd = 1'b1; @(negedge clk); lsr_rd = 1'b0;
    endtask

    function automatic int trig_of(input int code);
        case (code)
            0: return 1;
            1: return 4;
            2: return 8;
            default: return 14;
        endcase
    endfunction

    task automatic measure(output int n);
        n = 0;
        while (!rx_timeout && n < 300) begin
            @(negedge clk);
            n++;
        end
    endtask

    initial begin
        #2ms;
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int n, lim;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check(lsr == 8'h20, "R1 lsr", lsr, 8'h20);
        check(!rx_data_avail && !rx_timeout && !tx_fifo_clr && rd_data == 0, "R1 outputs",
              {rx_data_avail, rx_timeout, tx_fifo_clr}, 0);
        // R8 pass-through of transmit status
        tx_idle = 1'b1; tx_hold_empty = 1'b0; #1ns;
        check(lsr[6:5] == 2'b10, "R8 tx bits", lsr[6:5], 2);
        tx_idle = 1'b0; tx_hold_empty = 1'b1;

        // R4 R5 R6 trigger sweep, fill, overrun, order
        for (int t = 0; t < 4; t++) begin
            wr_fcr(8'(t << 6) | 8'h03);
            for (int k = 1; k <= 16; k++) begin
                push(8'(k + 16 * t), 3'b000);
                check(rx_data_avail == (k >= trig_of(t)), "R4 avail vs count", rx_data_avail, k >= trig_of(t));
            end
            check(lsr[1] == 1'b0, "R6 no overrun at 16", lsr[1], 0);
            push(8'hEE, 3'b000);
            check(lsr[1] == 1'b1, "R6 overrun set", lsr[1], 1);
            rd_lsr();
            check(lsr[1] == 1'b0, "R6 overrun cleared by lsr read", lsr[1], 0);
            for (int k = 1; k <= 16; k++) begin
                check(rd_data == 8'(k + 16 * t), "R5 order", rd_data, k + 16 * t);
                rd();
            end
            check(lsr[0] == 1'b0 && rd_data == 0, "R5 empty after 16 reads", lsr[0], 0);
        end

        // R6 simultaneous read and arrival on a full buffer is accepted
        wr_fcr(8'h03);
        for (int k = 0; k < 16; k++) push(8'(k), 3'b000);
        rx_valid = 1'b1; rx_byte = 8'h99; rbr_rd = 1'b1;
        @(negedge clk);
        rx_valid = 1'b0; rbr_rd = 1'b0;
        check(lsr[1] == 1'b0, "R6 no overrun on read+arrive", lsr[1], 0);
        for (int k = 1; k < 16; k++) rd();
        check(rd_data == 8'h99, "R6 last byte kept", rd_data, 8'h99);

        // R3 flush bits
        wr_fcr(8'h03);
        push(8'h11, 3'b000);
        push(8'h22, 3'b000);
        wr_fcr(8'h05);
        check(lsr[0] == 1'b1 && rd_data == 8'h11, "R3 zero bit1 keeps data", rd_data, 8'h11);
        check(tx_fifo_clr == 1'b1, "R3 tx clear pulse", tx_fifo_clr, 1);
        @(negedge clk);
        check(tx_fifo_clr == 1'b0, "R3 tx clear one cycle", tx_fifo_clr, 0);
        fcr_wr = 1'b1; fcr_data = 8'h03; rx_valid = 1'b1; rx_byte = 8'h33;
        @(negedge clk);
        fcr_wr = 1'b0; rx_valid = 1'b0;
        check(lsr[0] == 1'b0, "R3 flush drops data", lsr[0], 0);
        check(tx_fifo_clr == 1'b0, "R3 bit2 zero no pulse", tx_fifo_clr, 0);

        // R8 R9 error flags
        push(8'h01, 3'b000);
        push(8'h02, 3'b010);
        push(8'h03, 3'b000);
        check(lsr[4:2] == 3'b000 && lsr[7], "R9 error somewhere", lsr, 8'ha1);
        rd();
        check(lsr[4:2] == 3'b010, "R8 head framing", lsr[4:2], 2);
        rd();
        check(lsr[7] == 1'b0 && lsr[4:2] == 0, "R9 error gone", lsr[7], 0);
        rd();
        push(8'h04, 3'b101);
        check(lsr[4:2] == 3'b101, "R8 head parity+break", lsr[4:2], 5);
        rd();

        // R10 timeout length over all 16 formats
        baud_tick = 1'b1;
        for (int f = 0; f < 16; f++) begin
            lcr_fmt = 4'(f);
            lim = 4 * (7 + (f & 3) + ((f >> 3) & 1) + ((f >> 2) & 1));
            wr_fcr(8'h03);
            push(8'h5A, 3'b000);
            measure(n);
            check(n == lim + 1, "R10 window from empty", n, lim + 1);
            push(8'h5B, 3'b000);
            check(!rx_timeout, "R11 cleared after arrival", rx_timeout, 0);
            measure(n);
            check(n == lim, "R10 window after service", n, lim);
            rd();
            rd();
            check(!rx_timeout && lsr[0] == 0, "R11 empty clears timeout", rx_timeout, 0);
        end

        // R11 read restarts timer
        lcr_fmt = 4'h3;
        lim = 40;
        wr_fcr(8'h03);
        push(8'h61, 3'b000);
        push(8'h62, 3'b000);
        repeat (20) @(negedge clk);
        rd();
        measure(n);
        check(n == lim, "R11 read restarts window", n, lim);
        rd();

        // R2 R7 holding mode
        wr_fcr(8'h03);
        push(8'h70, 3'b000);
        wr_fcr(8'h00);
        check(lsr[0] == 1'b0, "R2 mode change empties", lsr[0], 0);
        push(8'h71, 3'b001);
        check(rx_data_avail && lsr[0], "R7 avail in holding mode", rx_data_avail, 1);
        check(lsr[7] == 1'b0, "R9 bit7 zero in holding mode", lsr[7], 0);
        push(8'h72, 3'b000);
        check(lsr[1] == 1'b1 && rd_data == 8'h71, "R6 holding overrun keeps first", rd_data, 8'h71);
        n = 0;
        for (int c = 0; c < 200; c++) begin
            @(negedge clk);
            if (rx_timeout) n++;
        end
        check(n == 0, "R7 no timeout in holding mode", n, 0);
        rd();
        check(!rx_data_avail, "R7 avail drops after read", rx_data_avail, 0);
        wr_fcr(8'hC1);
        for (int k = 0; k < 13; k++) push(8'(k), 3'b000);
        check(!rx_data_avail, "R4 13 below level 14", rx_data_avail, 0);
        push(8'h0D, 3'b000);
        check(rx_data_avail, "R2 FIFO mode reenabled, level 14", rx_data_avail, 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule